// File: doc/BRIEF.md
# FM Read-Pulse Clock/Data Separator

This block takes the raw pulse stream that a single-density floppy drive produces when it reads and splits it into two strobes. One carries the clock pulses and the other carries the data pulses. Every FM bit cell starts with a clock pulse. A data pulse follows half a cell later only when the bit is a one. The separator runs a small window counter from a slow tick derived from the system clock. Each incoming pulse reloads the counter, which pulls the window back into line with the stream. The counter's top bit then decides which output receives that pulse.

The read input is asynchronous and is synchronized inside the block. Each separated pulse leaves the block as a single system-clock strobe, and the downstream formatter reacts to its leading edge. The block has no phase lock at start-up. Until the formatter resynchronizes on a run of zero bytes, clock and data pulses can come out on the wrong strobes.

Top module: `fm_pulse_separator`

## Requirements
- R1: The read input passes through a synchronizer of SYNC_STAGES flops (default 2). Each low-to-high transition of the input causes exactly one load event. An input held high for any length of time produces no further loads.
- R2: On a load, the CNT_W-bit window counter (default 4) keeps its current top bit. Its lower bits are set to the pattern that leaves the counter 3 ticks short of a top-bit change: binary 101 for 4 bits, so the counter becomes {top,1,0,1}.
- R3: A counter tick occurs once every CLK_DIV system clocks (default 50, which gives 2 MHz from 100 MHz). Every load restarts the tick divider, so the first tick after a load comes CLK_DIV clocks later. Each tick without a load advances the counter by one.
- R4: After a load, the top bit toggles on the 3rd tick. While no further load arrives, it toggles again every 8 ticks after that.
- R5: A pulse is routed by the top bit the counter holds just before that pulse's load. A top bit of 0 sends it to clk_pulse_o and a top bit of 1 sends it to dat_pulse_o. Exactly one of the two outputs fires for each load.
- R6: Each output strobe is one system clock wide. If the read input is first seen high at rising edge k, the strobe is high during the cycle after edge k+2.
- R7: In a nominal stream with 16 ticks per bit cell, pulses stay correctly routed when they are displaced by up to 3 ticks early or late from their nominal position. Clock pulses come every cell, and data pulses come at mid-cell.
- R8: There is no phase lock. A pulse that arrives inside the opposite window goes to the other output, and later pulses are routed relative to it.
- R9: An active-low reset clears the window counter, the tick divider, the synchronizer and both outputs. The reset asserts asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_pulse_i | input | 1 | Raw FM read pulses from the drive, asynchronous |
| clk_pulse_o | output | 1 | One-cycle strobe for a pulse taken as a clock bit |
| dat_pulse_o | output | 1 | One-cycle strobe for a pulse taken as a data bit |

## Verification
The hardest state to reach from the ports is the exact tick on which the window's top bit flips. The counter is never visible, so the only way to observe its value is to route a later pulse. The bench runs the divider at 4 clocks per tick and fixes every pulse-to-pulse spacing in system cycles, which makes the number of ticks between loads exact. Spacing pairs such as 12/13 and 44/45 cycles put a second pulse on either side of the 3-tick flip and the following 8-tick flip. Deliberately late pulses show the outputs swapping.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;

  // Window state seen by a pulse at the moment it reloads the counter.
  typedef enum logic {
    ROUTE_CLK = 1'b0,
    ROUTE_DAT = 1'b1
  } route_e;

endpackage

// File: rtl/fmsep_edge.sv
module fmsep_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic load_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  logic          prev_q, prev_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], pin_i};
    end else begin : g_single
      always_comb sync_d = pin_i;
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign load_o = sync_q[LAST] & ~prev_q;

  // R1: a load never lasts longer than one cycle
  p_single_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

endmodule

// File: rtl/fmsep_prescale.sv
module fmsep_prescale #(
  parameter int CLK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;

  assign tick_o = (div_q == DIV_LAST);
  assign div_en = 1'b1;

  always_comb begin
    div_d = div_q;
    if (restart_i || tick_o) div_d = '0;
    else if (div_en)         div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  generate
    if (CLK_DIV > 1) begin : g_chk
      // R3: a restart delays the next tick by at least one full period
      p_restart_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/fmsep_window.sv
module fmsep_window #(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic top_o
);

  localparam int TOP = CNT_W - 1;
  // Lower bits chosen so the top bit flips after exactly 3 ticks.
  localparam logic [TOP-1:0] LOAD_LOW = TOP'((1 << TOP) - 3);

  logic [TOP:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = {cnt_q[TOP], LOAD_LOW};
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign top_o = cnt_q[TOP];

  // R2: reload keeps the top bit and forces the fixed low pattern
  p_load_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q[TOP-1:0] == LOAD_LOW) && (cnt_q[TOP] == $past(cnt_q[TOP])));

  // R3: an unloaded tick advances the window by one
  p_tick_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3: without tick or load the window holds
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/fm_pulse_separator.sv
module fm_pulse_separator #(
  parameter int CLK_DIV     = 50,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_pulse_i,
  output logic clk_pulse_o,
  output logic dat_pulse_o
);

  import fmsep_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       load;
  logic       tick;
  logic       top;
  route_e     route;
  logic       clk_d, dat_d;
  logic       clk_q, dat_q;

  // Reset: asynchronous assert, clocked release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  fmsep_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (rd_pulse_i),
    .load_o (load)
  );

  fmsep_prescale #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .restart_i (load),
    .tick_o    (tick)
  );

  fmsep_window #(.CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (load),
    .tick_i (tick),
    .top_o  (top)
  );

  assign route = route_e'(top);

  always_comb begin
    clk_d = load && (route == ROUTE_CLK);
    dat_d = load && (route == ROUTE_DAT);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      clk_q <= clk_d;
      dat_q <= dat_d;
    end
  end

  assign clk_pulse_o = clk_q;
  assign dat_pulse_o = dat_q;

  // R5: never both strobes at once
  p_one_output_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({clk_pulse_o, dat_pulse_o}));

  // R5: every load yields exactly one strobe
  p_load_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    load |=> (clk_pulse_o || dat_pulse_o));

  // R6: strobes are a single cycle wide
  p_clk_width_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    clk_pulse_o |=> !clk_pulse_o);
  p_dat_width_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    dat_pulse_o |=> !dat_pulse_o);

endmodule

// File: tb/tb_fm_pulse_separator.sv
`timescale 1ns/1ps
module tb_fm_pulse_separator;

  localparam int DIV   = 4;
  localparam int NVEC  = 15;
  // Raise-to-raise spacing in system cycles, and expected routing (1 = data)
  localparam int VEC_GAP [NVEC] = '{64, 32, 32, 40, 24, 52, 76, 20, 44, 12, 13, 12, 45, 32, 80};
  localparam bit VEC_DAT [NVEC] = '{ 0,  1,  0,  1,  0,  0,  0,  1,  0,  0,  1,  1,  1,  0,  1};

  logic clk = 1'b0;
  logic rst_n;
  logic rd;
  logic clk_p, dat_p;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  fm_pulse_separator #(.CLK_DIV(DIV), .CNT_W(4), .SYNC_STAGES(2)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rd_pulse_i  (rd),
    .clk_pulse_o (clk_p),
    .dat_pulse_o (dat_p)
  );

  task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: {dat,clk} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: raises the input there, returns four negedges later.
  task automatic send_pulse(input bit exp_dat, input string req);
    logic [1:0] e;
    e = exp_dat ? 2'b10 : 2'b01;
    rd = 1'b1;
    @(negedge clk);
    @(negedge clk) rd = 1'b0;
    @(negedge clk);
    check({dat_p, clk_p} == e, req, {dat_p, clk_p}, e);
    @(negedge clk);
    check({dat_p, clk_p} == 2'b00, "R6 width", {dat_p, clk_p}, 2'b00);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int hits;
    rd    = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs cleared during reset
    check({dat_p, clk_p} == 2'b00, "R9 reset", {dat_p, clk_p}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // First pulse: counter still low after reset, so clock window (R5, R9)
    send_pulse(1'b0, "R5 first");

    // Vector walk: R4 boundaries (gaps 12/13, 44/45), R7 jitter, R8 swap
    for (int i = 0; i < NVEC; i++) begin
      repeat (VEC_GAP[i] - 4) @(negedge clk);
      send_pulse(VEC_DAT[i], $sformatf("R4/R5/R7/R8 vec%0d", i));
    end

    // R1: long high level gives one strobe only
    repeat (40) @(negedge clk);
    hits = 0;
    rd = 1'b1;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      hits += int'(clk_p) + int'(dat_p);
    end
    rd = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      hits += int'(clk_p) + int'(dat_p);
    end
    check(hits == 1, "R1 held high", 2'(hits), 2'd1);

    // R9/R2: state after a data pulse is cleared by reset
    repeat (10) @(negedge clk);
    send_pulse(1'b1, "R8 pre-reset swap");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_pulse(1'b0, "R9 counter cleared");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule